// File: doc/BRIEF.md
# Translation Buffer Entry Management Registers

This block gives software three 32-bit control registers through which it fills and inspects the entries of a set-associative address translation buffer. One register carries the entry data (frame number and access rights), one carries the way selector, the process identifier and the read and write-enable strobes, and one carries the virtual page number that picks the set. Writing the data register while write-enable is set stores one entry and steps the way selector, so software can fill all ways of a set by writing the data register once per way. Writing the miscellaneous register with its read strobe set loads the selected entry back into the three read-back values.

Each register keeps the value software last wrote apart from the value it reads back. Entries always take their page number and process identifier from the last written values, whatever a read-back operation did since. The entry storage is shared with the lookup unit, which sees it through an indexed lookup port.

Top module: `tlbm_ctrl`

## Requirements
- R1: With write-enable (misc bit 16) set in the misc read-back value, a write to the data register (select 0) stores one entry at the index of R9 built from the misc way field (bits 25:24), the last written page number and the last written process ID; the lookup port shows it from the next cycle.
- R2: A stored tag is {page number[19:0] at bits 29:10, global bit 9 taken from data bit 24, valid bit 8, process ID at bits 7:0}; valid is 1 only when the page number is below 0xC0000.
- R3: Stored entry data is data bits 23:0 only: frame number 19:0, C bit 20, R bit 21, W bit 22, X bit 23.
- R4: After each entry write the misc way field increments modulo the number of ways; a data write without write-enable stores nothing and leaves the way field unchanged.
- R5: A write to the data register never changes the data register's read-back value.
- R6: A misc write (select 1) with the read strobe (bit 17) set reads the entry at way bits 25:24 of the written value: data read-back becomes (old read-back AND bits 31:25) OR entry data OR (tag global bit at bit 24); misc read-back becomes the written value with bits 7:0 replaced by the entry's process ID; the address read-back page number (bits 21:2) becomes the tag page number.
- R7: A misc write without the read strobe sets the misc read-back value to the written value.
- R8: A write to the address register (select 2) updates all read-back bits except the page number bits 21:2, which keep their value.
- R9: The entry index is way × number_of_ways + (page number AND (number_of_ways − 1)).
- R10: After reset all read-back values are zero and every entry tag and data is zero.
- R11: The process ID written into a new entry is the last written misc bits 7:0, even when a read since then replaced the read-back process ID.
- R12: Select 3 writes change nothing and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for write: 0 data, 1 misc, 2 address |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register select for read |
| rd_data_o | output | 32 | Read-back value of the selected register |
| lk_idx_i | input | 4 | Entry index for the lookup port |
| lk_tag_o | output | 30 | Tag of the entry at lk_idx_i |
| lk_data_o | output | 24 | Data of the entry at lk_idx_i |

## Verification
A wrong way counter, a stale page number or a misplaced index shows up on the lookup port in the cycle right after the faulty entry write, because the bench scans every entry through that port each clock. A read-back register that takes a field from the wrong source, or that changes on a write meant to leave it alone, differs from the reference model at the read port one cycle after the offending write. The tag's valid bit around the 0xC0000 boundary, the way wrap and the split between written and read-back process ID each get directed checks with hand-derived values.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_MISC = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int REG_W        = 32;
  localparam int DATA_W       = 24;
  localparam int VPN_W        = 20;
  localparam int VPN_LSB      = 2;
  localparam int ACC_G        = 24;
  localparam int MISC_WE      = 16;
  localparam int MISC_RD      = 17;
  localparam int MISC_WAY_LSB = 24;
  localparam logic [REG_W-1:0] ACC_IG_MASK = 32'hFE00_0000;
  localparam logic [VPN_W-1:0] VALID_LIMIT = 20'hC0000;
endpackage

// File: rtl/tlbm_index.sv
module tlbm_index #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int IDX_W   = 2 * WAY_W
) (
  input  logic [WAY_W-1:0] way_i,
  input  logic [WAY_W-1:0] vpn_lo_i,
  output logic [IDX_W-1:0] idx_o
);
  // way * ways + (vpn & (ways-1))
  assign idx_o = IDX_W'(way_i) * IDX_W'(NUM_WAYS) + IDX_W'(vpn_lo_i);
endmodule

// File: rtl/tlbm_store.sv
module tlbm_store #(
  parameter int N_ENT  = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 30,
  parameter int DATA_W = 24,
  parameter int PID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [TAG_W-1:0]  rtag_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  lidx_i,
  output logic [TAG_W-1:0]  ltag_o,
  output logic [DATA_W-1:0] ldata_o
);
  logic [TAG_W-1:0]  tag_q  [N_ENT];
  logic [DATA_W-1:0] data_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[e]  <= '0;
        data_q[e] <= '0;
      end else if (we_i && (widx_i == IDX_W'(e))) begin
        tag_q[e]  <= wtag_i;
        data_q[e] <= wdata_i;
      end
    end
  end

  assign rtag_o  = tag_q[ridx_i];
  assign rdata_o = data_q[ridx_i];
  assign ltag_o  = tag_q[lidx_i];
  assign ldata_o = data_q[lidx_i];

  AST_ENTRY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tag_q[$past(widx_i)] == $past(wtag_i)) && (data_q[$past(widx_i)] == $past(wdata_i))); // R1
  AST_VALID_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (wtag_i[PID_W] == (wtag_i[TAG_W-1 -: 20] < 20'hC0000))); // R2
endmodule

// File: rtl/tlbm_regs.sv
module tlbm_regs
  import tlbm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PID_W    = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int IDX_W   = 2 * WAY_W,
  localparam int TAG_W   = VPN_W + 2 + PID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              ent_we_o,
  output logic [IDX_W-1:0]  ent_widx_o,
  output logic [TAG_W-1:0]  ent_wtag_o,
  output logic [DATA_W-1:0] ent_wdata_o,
  output logic [IDX_W-1:0]  ent_ridx_o,
  input  logic [TAG_W-1:0]  ent_rtag_i,
  input  logic [DATA_W-1:0] ent_rdata_i
);
  logic [REG_W-1:0] acc_rb_q, misc_rb_q, addr_rb_q;
  logic [PID_W-1:0] wr_pid_q;
  logic [VPN_W-1:0] wr_vpn_q;

  logic wr_acc, wr_misc, wr_addr, rd_req;
  logic [WAY_W-1:0] cur_way, rd_way;
  logic             new_valid;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;
  logic             rd_g;
  logic             unused_rd_valid;

  assign wr_acc  = wr_en_i && (wr_sel_i == SEL_ACC);
  assign wr_misc = wr_en_i && (wr_sel_i == SEL_MISC);
  assign wr_addr = wr_en_i && (wr_sel_i == SEL_ADDR);
  assign rd_req  = wr_misc && wr_data_i[MISC_RD];

  assign cur_way = misc_rb_q[MISC_WAY_LSB +: WAY_W];
  assign rd_way  = wr_data_i[MISC_WAY_LSB +: WAY_W];

  // entry write path
  tlbm_index #(.NUM_WAYS(NUM_WAYS)) i_widx (
    .way_i    (cur_way),
    .vpn_lo_i (wr_vpn_q[WAY_W-1:0]),
    .idx_o    (ent_widx_o)
  );

  // entry read-back path
  tlbm_index #(.NUM_WAYS(NUM_WAYS)) i_ridx (
    .way_i    (rd_way),
    .vpn_lo_i (wr_vpn_q[WAY_W-1:0]),
    .idx_o    (ent_ridx_o)
  );

  assign new_valid   = (wr_vpn_q < VALID_LIMIT);
  assign ent_we_o    = wr_acc && misc_rb_q[MISC_WE];
  assign ent_wtag_o  = {wr_vpn_q, wr_data_i[ACC_G], new_valid, wr_pid_q};
  assign ent_wdata_o = wr_data_i[DATA_W-1:0];

  assign rd_pid          = ent_rtag_i[PID_W-1:0];
  assign unused_rd_valid = ent_rtag_i[PID_W];
  assign rd_g            = ent_rtag_i[PID_W+1];
  assign rd_vpn          = ent_rtag_i[TAG_W-1 -: VPN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_rb_q  <= '0;
      misc_rb_q <= '0;
      addr_rb_q <= '0;
      wr_pid_q  <= '0;
      wr_vpn_q  <= '0;
    end else if (wr_acc) begin
      if (misc_rb_q[MISC_WE]) begin
        misc_rb_q[MISC_WAY_LSB +: WAY_W] <= cur_way + WAY_W'(1);
      end
    end else if (wr_misc) begin
      wr_pid_q <= wr_data_i[PID_W-1:0];
      if (rd_req) begin
        acc_rb_q  <= (acc_rb_q & ACC_IG_MASK) | REG_W'(ent_rdata_i)
                   | (REG_W'(rd_g) << ACC_G);
        misc_rb_q <= {wr_data_i[REG_W-1:PID_W], rd_pid};
        addr_rb_q[VPN_LSB +: VPN_W] <= rd_vpn;
      end else begin
        misc_rb_q <= wr_data_i;
      end
    end else if (wr_addr) begin
      wr_vpn_q  <= wr_data_i[VPN_LSB +: VPN_W];
      addr_rb_q <= {wr_data_i[REG_W-1:VPN_LSB+VPN_W],
                    addr_rb_q[VPN_LSB +: VPN_W],
                    wr_data_i[VPN_LSB-1:0]};
    end
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_ACC:  rd_data_o = acc_rb_q;
      SEL_MISC: rd_data_o = misc_rb_q;
      SEL_ADDR: rd_data_o = addr_rb_q;
      default:  rd_data_o = '0;
    endcase
  end

  AST_ACC_RB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> $stable(acc_rb_q)); // R5
  AST_WAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_we_o |=> (cur_way == WAY_W'($past(cur_way) + WAY_W'(1)))); // R4
  AST_WAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && !misc_rb_q[MISC_WE]) |=> $stable(misc_rb_q)); // R4
  AST_MISC_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misc && !wr_data_i[MISC_RD]) |=> (misc_rb_q == $past(wr_data_i))); // R7
  AST_ADDR_VPN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr |=> $stable(addr_rb_q[VPN_LSB +: VPN_W])); // R8
  AST_NONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_sel_i == SEL_NONE)) |=> ($stable(acc_rb_q) && $stable(misc_rb_q) && $stable(addr_rb_q))); // R12
endmodule

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int PID_W    = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int IDX_W   = 2 * WAY_W,
  localparam int N_ENT   = NUM_WAYS * NUM_WAYS,
  localparam int TAG_W   = VPN_W + 2 + PID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [31:0]       rd_data_o,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o
);
  logic              ent_we;
  logic [IDX_W-1:0]  ent_widx, ent_ridx;
  logic [TAG_W-1:0]  ent_wtag, ent_rtag;
  logic [DATA_W-1:0] ent_wdata, ent_rdata;

  tlbm_regs #(.NUM_WAYS(NUM_WAYS), .PID_W(PID_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .ent_we_o    (ent_we),
    .ent_widx_o  (ent_widx),
    .ent_wtag_o  (ent_wtag),
    .ent_wdata_o (ent_wdata),
    .ent_ridx_o  (ent_ridx),
    .ent_rtag_i  (ent_rtag),
    .ent_rdata_i (ent_rdata)
  );

  tlbm_store #(
    .N_ENT(N_ENT), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .PID_W(PID_W)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ent_we),
    .widx_i  (ent_widx),
    .wtag_i  (ent_wtag),
    .wdata_i (ent_wdata),
    .ridx_i  (ent_ridx),
    .rtag_o  (ent_rtag),
    .rdata_o (ent_rdata),
    .lidx_i  (lk_idx_i),
    .ltag_o  (lk_tag_o),
    .ldata_o (lk_data_o)
  );
endmodule

// File: tb/test_tlbm_ctrl.sv
`timescale 1ns/10ps
module test_tlbm_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [31:0] wr_data_i = 32'd0;
  logic [1:0]  rd_sel_i = 2'd0;
  logic [31:0] rd_data_o;
  logic [3:0]  lk_idx_i = 4'd0;
  logic [29:0] lk_tag_o;
  logic [23:0] lk_data_o;

  tlbm_ctrl i_tlbm_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [29:0] m_tag  [16];
  logic [23:0] m_data [16];
  logic [31:0] m_acc, m_misc, m_addr;
  logic [7:0]  m_pid;
  logic [19:0] m_vpn;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel_i = s;
    #0.01;
    v = rd_data_o;
  endtask

  task automatic lk(input int i, output logic [29:0] t, output logic [23:0] d);
    lk_idx_i = 4'(i);
    #0.01;
    t = lk_tag_o;
    d = lk_data_o;
  endtask

  task automatic compare_all();
    logic [31:0] v;
    logic [29:0] t;
    logic [23:0] d;
    rd(2'd0, v); chk("R5/R6 data read-back", v, m_acc);
    rd(2'd1, v); chk("R4/R6/R7 misc read-back", v, m_misc);
    rd(2'd2, v); chk("R6/R8 address read-back", v, m_addr);
    rd(2'd3, v); chk("R12 unused select", v, 32'd0);
    for (int i = 0; i < 16; i++) begin
      lk(i, t, d);
      chk("R1/R2/R9/R11 entry tag", 32'(t), 32'(m_tag[i]));
      chk("R1/R3 entry data", 32'(d), 32'(m_data[i]));
    end
  endtask

  task automatic model_apply(logic [1:0] s, logic [31:0] v);
    int way, idx;
    case (s)
      2'd0: if (m_misc[16]) begin
        way = int'(m_misc[25:24]);
        idx = way * 4 + int'(m_vpn & 20'h3);
        m_tag[idx]  = {m_vpn, v[24], (m_vpn < 20'hC0000), m_pid};
        m_data[idx] = v[23:0];
        m_misc[25:24] = 2'((way + 1) % 4);
      end
      2'd1: begin
        m_pid = v[7:0];
        if (v[17]) begin
          way = int'(v[25:24]);
          idx = way * 4 + int'(m_vpn & 20'h3);
          m_acc  = (m_acc & 32'hFE00_0000) | {8'd0, m_data[idx]} | {7'd0, m_tag[idx][9], 24'd0};
          m_misc = {v[31:8], m_tag[idx][7:0]};
          m_addr[21:2] = m_tag[idx][29:10];
        end else m_misc = v;
      end
      2'd2: begin
        m_addr = {v[31:22], m_addr[21:2], v[1:0]};
        m_vpn  = v[21:2];
      end
      default: ;
    endcase
  endtask

  task automatic step(logic [1:0] s, logic [31:0] v);
    @(negedge clk_i);
    compare_all();
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = v;
    @(posedge clk_i);
    model_apply(s, v);
    #0.1;
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [29:0] t;
    logic [23:0] d;
    for (int i = 0; i < 16; i++) begin m_tag[i] = '0; m_data[i] = '0; end
    m_acc = '0; m_misc = '0; m_addr = '0; m_pid = '0; m_vpn = '0;
    #12 rst_ni = 1'b1;

    // R10 reset state
    @(negedge clk_i);
    rd(2'd0, v); chk("R10 data reset", v, 32'd0);
    rd(2'd1, v); chk("R10 misc reset", v, 32'd0);
    lk(7, t, d); chk("R10 entry reset", 32'(t) | 32'(d), 32'd0);

    // R8 page number kept in read-back
    step(2'd2, 32'h002F_FFFF);
    rd(2'd2, v); chk("R8 address write keeps page number", v, 32'h0000_0003);
    // R7 plain misc write: pid 5A, write-enable, way 2
    step(2'd1, 32'h0201_005A);
    rd(2'd1, v); chk("R7 misc write", v, 32'h0201_005A);
    // R1 R2 R3 R9: vpn BFFFF, way 2 -> index 11, global, valid
    step(2'd0, 32'hFFFF_FFFF);
    lk(11, t, d);
    chk("R1/R2/R9 tag at index 11", 32'(t), 32'h2FFF_FF5A);
    chk("R3 data masked", 32'(d), 32'h00FF_FFFF);
    rd(2'd0, v); chk("R5 data read-back unchanged", v, 32'd0);
    rd(2'd1, v); chk("R4 way stepped to 3", v, 32'h0301_005A);
    // R2 vpn C0000 is not valid; way 3 -> index 12
    step(2'd2, 32'h0030_0000);
    step(2'd0, 32'h0000_1234);
    lk(12, t, d); chk("R2 invalid at 0xC0000", 32'(t), 32'h3000_005A);
    rd(2'd1, v); chk("R4 way wraps to 0", v, 32'h0001_005A);
    step(2'd0, 32'h01A5_4321);
    lk(0, t, d);
    chk("R2 global from data bit 24", 32'(t), 32'h3000_025A);
    chk("R3 data field", 32'(d), 32'h00A5_4321);
    // R6 read back index 11
    step(2'd2, 32'h0000_000C);
    step(2'd1, 32'h0202_0011);
    rd(2'd0, v); chk("R6 data read-back", v, 32'h01FF_FFFF);
    rd(2'd1, v); chk("R6 misc pid from entry", v, 32'h0202_005A);
    rd(2'd2, v); chk("R6 address page from tag", v, 32'h002F_FFFC);
    // R11 written pid used even after read replaced it
    step(2'd1, 32'h0303_0011);
    rd(2'd1, v); chk("R6 misc pid of empty entry", v, 32'h0303_0000);
    step(2'd0, 32'h0000_0777);
    lk(15, t, d); chk("R11 written pid in new tag", 32'(t), 32'h0000_0D11);
    // R4 no write-enable: nothing stored
    step(2'd1, 32'h0000_0000);
    step(2'd0, 32'h00BB_BBBB);
    lk(0, t, d); chk("R4 no store without write-enable", 32'(d), 32'h00A5_4321);
    rd(2'd1, v); chk("R4 way unchanged", v, 32'd0);
    // R12 select 3 ignored
    step(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R12 select 3 write ignored", v, 32'd0);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if ((n % 5) == 0) r[16] = 1'b1;
      if ((n % 7) != 0) r[17] = 1'b0;
      if ((n % 11) == 0) r[21:2] = 20'hC0000 - 20'(n % 3);
      step(2'($urandom % 4), r);
    end
    @(negedge clk_i);
    compare_all();
    finish_run();
  end
endmodule